// File: doc/BRIEF.md
# MSI Message Ring-Buffer Writer

This block takes message-signalled interrupt vectors that arrive on a valid/ready port and turns each one into a fixed 16-byte record. It writes each record into a circular buffer in host memory through a simple word-wide write-request port. Host software programs the buffer base address and the ring size. It consumes records at its own pace and tells the block how far it has read by writing a consumer offset. The block publishes its own producer offset in a register.

An interrupt line stays high while recording is enabled, the interrupt is enabled, and unread records exist. Full detection is optional. With stop-on-full also set, the block holds incoming messages back instead of overwriting records the host has not yet read.

Top module: `msi_ring_writer`

## Requirements
- R1: After a synchronous active-low reset the following are all zero: control, base address, read offset and write offset. `msi_ready`, `mem_valid` and `irq` are low.
- R2: Register word offsets are fixed. 0 is control, whose writable bits are 0, 1, 3, 4, 9 and 8; all other bits read zero. 3 is base address bits 63:32. 4 is base address bits 31:0, with bits 3:0 always reading zero. 5 is the read offset, bits 17:4 stored and all other bits reading zero. 6 is the write offset, which is read-only; a write to it changes nothing.
- R3: No message is accepted (`msi_ready` low) while control bit 0 (enable) is clear.
- R4: Each accepted message produces exactly four memory write beats, at addresses base+offset+0, +4, +8 and +12. The first beat carries the vector in bits 15:0 with bits 31:16 zero, little-endian, so bits 7:0 go to the lowest byte address. The other three beats carry zero.
- R5: The write offset advances by 16 once the fourth beat of a record has been accepted, and not before.
- R6: The ring size is 2^(15+c) bytes, where c is control bits 9:8. The write offset wraps from size-16 to zero, and both offsets are compared modulo the size.
- R7: The ring is full when (write offset + 16) mod size equals the read offset. When control bit 1 (full detection) and bit 4 (stop-on-full) are both set and the ring is full, `msi_ready` is low. With stop-on-full clear, messages are still accepted.
- R8: `irq` is high exactly when control bit 0 and bit 3 (interrupt enable) are both set and the write offset differs from the read offset.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R10: Clearing control bits 0 and 3 lowers `irq` and stops acceptance of further messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| msi_valid | input | 1 | Incoming message valid |
| msi_ready | output | 1 | Block can accept a message |
| msi_vector | input | 16 | Interrupt vector of the message |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Byte address of the write |
| mem_data | output | 32 | Write data word |
| irq | output | 1 | Interrupt to the host |

## Verification
The record path is exercised in several ways:
- A single vector with distinctive bytes confirms the field placement and the four-beat address stride.
- A record held under memory back-pressure separates a stalling writer from one that drops or skips beats.
- A long run of distinct vectors across the whole smallest ring confirms that the offset wraps at the configured size and not at the width of the counter.

The acceptance rules are exercised separately. The full-ring case is tried with stop-on-full set and then clear, which separates holding back messages from overwriting unread records. The interrupt line is checked with equal offsets, with unequal offsets, and after the enables are cleared.

// File: rtl/msi_ring_pkg.sv
// Package: shared constants and types for the MSI ring writer.
// Assumes byte addressing and 32-bit memory beats.
package msi_ring_pkg;

    // Register word offsets (decoded by host software)
    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_BASE_HI = 3'd3;
    localparam logic [2:0] REG_BASE_LO = 3'd4;
    localparam logic [2:0] REG_RD_OFF  = 3'd5;
    localparam logic [2:0] REG_WR_OFF  = 3'd6;

    // Control bit positions
    localparam int CB_EN      = 0;
    localparam int CB_FULL_EN = 1;
    localparam int CB_IRQ_EN  = 3;
    localparam int CB_STOP    = 4;
    localparam int CB_SIZE_LO = 8;

    // Writable control bits
    localparam logic [31:0] CTRL_WMASK = 32'h0000_031B;

    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_BEAT = 1'b1
    } rec_state_e;

endpackage

// File: rtl/msi_ring_regs.sv
// Module: host-visible register file.
// Holds control, base address and read offset; presents the write offset
// produced elsewhere. Read data is combinational from reg_sel.
// Assumes single-cycle register writes.
module msi_ring_regs
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int OFF_W     = 18,
    parameter int REC_SHIFT = 4,
    localparam int IDX_W    = OFF_W - REC_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [IDX_W-1:0]  wr_idx,
    output logic [31:0]       ctrl,
    output logic [ADDR_W-1:0] base,
    output logic [IDX_W-1:0]  rd_idx
);

    logic [31:0] base_hi;
    logic [31:0] base_lo;

    // Register writes; write offset register is read-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            base_hi <= '0;
            base_lo <= '0;
            rd_idx  <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                REG_CTRL:    ctrl    <= reg_wdata & CTRL_WMASK;
                REG_BASE_HI: base_hi <= reg_wdata;
                REG_BASE_LO: base_lo <= {reg_wdata[31:REC_SHIFT], {REC_SHIFT{1'b0}}};
                REG_RD_OFF:  rd_idx  <= reg_wdata[OFF_W-1:REC_SHIFT];
                default: ;
            endcase
        end
    end

    // Assemble the full base address
    always_comb base = ADDR_W'({base_hi, base_lo});

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            REG_CTRL:    reg_rdata = ctrl;
            REG_BASE_HI: reg_rdata = base_hi;
            REG_BASE_LO: reg_rdata = base_lo;
            REG_RD_OFF:  reg_rdata = 32'({rd_idx, {REC_SHIFT{1'b0}}});
            REG_WR_OFF:  reg_rdata = 32'({wr_idx, {REC_SHIFT{1'b0}}});
            default:     reg_rdata = '0;
        endcase
    end

    AST_CTRL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl & ~CTRL_WMASK) == 32'd0); // R2

endmodule

// File: rtl/msi_ring_ptr.sv
// Module: producer offset and ring occupancy.
// Keeps the write index (record units), wraps it at the configured ring
// size, and compares it with the host read index for full/non-empty.
// Assumes size_sel selects 2^(LOG_MIN+size_sel) bytes.
module msi_ring_ptr #(
    parameter int OFF_W      = 18,
    parameter int REC_SHIFT  = 4,
    parameter int SIZE_STEPS = 4,
    localparam int IDX_W     = OFF_W - REC_SHIFT,
    localparam int SEL_W     = $clog2(SIZE_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] size_sel,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             advance,
    output logic [IDX_W-1:0] wr_idx,
    output logic             full,
    output logic             nonempty
);

    localparam logic [IDX_W-1:0] IDX_ALL = '1;

    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] wr_raw;
    logic [IDX_W-1:0] wr_next;

    // Index mask for the selected ring size
    always_comb mask = IDX_ALL >> (IDX_W'(SIZE_STEPS - 1) - IDX_W'(size_sel));

    // Next index, wrapped at the ring end
    always_comb wr_next = (wr_raw + 1'b1) & mask;

    // Producer index register
    always_ff @(posedge clk) begin
        if (!rst_n) wr_raw <= '0;
        else if (advance) wr_raw <= wr_next;
    end

    // Occupancy compares modulo ring size
    always_comb begin
        wr_idx   = wr_raw & mask;
        full     = (wr_next == (rd_idx & mask));
        nonempty = (wr_idx != (rd_idx & mask));
    end

    AST_WR_MOVES_ON_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(wr_raw)); // R5

endmodule

// File: rtl/msi_ring_rec.sv
// Module: record sequencer.
// Accepts one vector, latches the record address, then issues the
// record's memory beats in order, holding each under back-pressure.
// Assumes rec_addr is aligned to the record size.
module msi_ring_rec
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int VEC_W     = 16,
    parameter int DATA_W    = 32,
    parameter int REC_BYTES = 16,
    localparam int BEATS    = REC_BYTES / (DATA_W / 8),
    localparam int BEAT_W   = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_ok,
    input  logic              msi_valid,
    output logic              msi_ready,
    input  logic [VEC_W-1:0]  msi_vector,
    input  logic [ADDR_W-1:0] rec_addr,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              advance
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    rec_state_e        state;
    logic [BEAT_W-1:0] beat;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] addr_q;
    logic              take;
    logic              beat_done;

    // Handshake and beat completion
    always_comb begin
        msi_ready = (state == RS_IDLE) && accept_ok;
        take      = msi_ready && msi_valid;
        mem_valid = (state == RS_BEAT);
        beat_done = mem_valid && mem_ready;
        advance   = beat_done && (beat == LAST_BEAT);
    end

    // Sequencer state, beat counter and latched record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RS_IDLE;
            beat   <= '0;
            vec_q  <= '0;
            addr_q <= '0;
        end else begin
            case (state)
                RS_IDLE: if (take) begin
                    state  <= RS_BEAT;
                    beat   <= '0;
                    vec_q  <= msi_vector;
                    addr_q <= rec_addr;
                end
                RS_BEAT: if (beat_done) begin
                    if (beat == LAST_BEAT) state <= RS_IDLE;
                    beat <= beat + 1'b1;
                end
                default: state <= RS_IDLE;
            endcase
        end
    end

    // Beat address and data; vector sits in the low bits of the first word
    always_comb begin
        mem_addr = addr_q + ADDR_W'({beat, 2'b00});
        mem_data = (beat == '0) ? DATA_W'(vec_q) : '0;
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R9
    AST_BEAT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[1:0] == 2'b00); // R4
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !msi_ready); // R4

endmodule

// File: rtl/msi_ring_writer.sv
// Module: MSI message ring-buffer writer (top).
// Stores each accepted interrupt vector as a 16-byte record in a host
// memory ring and raises irq while unread records remain.
// Assumes the host keeps the read offset inside the configured ring.
module msi_ring_writer
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int VEC_W      = 16,
    parameter int DATA_W     = 32,
    parameter int LOG_MIN    = 15,
    parameter int SIZE_STEPS = 4,
    parameter int REC_SHIFT  = 4,
    localparam int OFF_W     = LOG_MIN + SIZE_STEPS - 1,
    localparam int IDX_W     = OFF_W - REC_SHIFT,
    localparam int SEL_W     = $clog2(SIZE_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              msi_valid,
    output logic              msi_ready,
    input  logic [VEC_W-1:0]  msi_vector,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              irq
);

    logic [31:0]       ctrl;
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic              full;
    logic              nonempty;
    logic              advance;
    logic              stall;
    logic              accept_ok;
    logic [ADDR_W-1:0] rec_addr;

    msi_ring_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .REC_SHIFT(REC_SHIFT)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_idx(wr_idx),
        .ctrl(ctrl), .base(base), .rd_idx(rd_idx)
    );

    msi_ring_ptr #(.OFF_W(OFF_W), .REC_SHIFT(REC_SHIFT), .SIZE_STEPS(SIZE_STEPS)) u_ptr (
        .clk(clk), .rst_n(rst_n), .size_sel(ctrl[CB_SIZE_LO +: SEL_W]),
        .rd_idx(rd_idx), .advance(advance), .wr_idx(wr_idx),
        .full(full), .nonempty(nonempty)
    );

    // Acceptance policy and record address
    always_comb begin
        stall     = ctrl[CB_FULL_EN] && ctrl[CB_STOP] && full;
        accept_ok = ctrl[CB_EN] && !stall;
        rec_addr  = base + ADDR_W'({wr_idx, {REC_SHIFT{1'b0}}});
    end

    msi_ring_rec #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .DATA_W(DATA_W),
                   .REC_BYTES(1 << REC_SHIFT)) u_rec (
        .clk(clk), .rst_n(rst_n), .accept_ok(accept_ok),
        .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_vector(msi_vector),
        .rec_addr(rec_addr), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .advance(advance)
    );

    // Host interrupt while unread records exist
    always_comb irq = ctrl[CB_EN] && ctrl[CB_IRQ_EN] && nonempty;

    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        msi_ready |-> ctrl[CB_EN]); // R3
    AST_FULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[CB_FULL_EN] && ctrl[CB_STOP] && full |-> !msi_ready); // R7
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[CB_EN] && ctrl[CB_IRQ_EN]) |-> !irq); // R10

endmodule

// File: tb/sim_msi_ring_writer.sv
// Directed bench for msi_ring_writer; each scenario task checks itself.
module sim_msi_ring_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msi_valid = 1'b0;
    logic        msi_ready;
    logic [15:0] msi_vector = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_base;
    logic [31:0] exp_wr;
    logic [63:0] got_addr [4];
    logic [31:0] got_data [4];

    always #2.5 clk = ~clk;

    msi_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
        .msi_ready(msi_ready), .msi_vector(msi_vector), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [31:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    // Offer one vector and collect its four beats
    task automatic send(input logic [15:0] vec, input int hold_cycles);
        int guard = 0;
        @(negedge clk);
        msi_valid = 1'b1; msi_vector = vec;
        while (!msi_ready && guard < 100) begin
            @(negedge clk); guard++;
        end
        @(posedge clk);
        #1 msi_valid = 1'b0;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            if (b == 1 && hold_cycles > 0) begin
                logic [63:0] a0;
                logic [31:0] d0;
                mem_ready = 1'b0;
                a0 = mem_addr; d0 = mem_data;
                repeat (hold_cycles) @(negedge clk);
                check("R9 hold valid", {63'd0, mem_valid}, 64'd1);
                check("R9 hold addr", mem_addr, a0);
                check("R9 hold data", {32'd0, mem_data}, {32'd0, d0});
                mem_ready = 1'b1;
            end
            got_addr[b] = mem_valid ? mem_addr : 64'hDEAD;
            got_data[b] = mem_valid ? mem_data : 32'hDEAD;
            @(posedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 ready", {63'd0, msi_ready}, 64'd0);
        check("R1 mem_valid", {63'd0, mem_valid}, 64'd0);
        check("R1 irq", {63'd0, irq}, 64'd0);
        rd_reg(3'd0, v); check("R1 ctrl", {32'd0, v}, 64'd0);
        rd_reg(3'd6, v); check("R1 wr offset", {32'd0, v}, 64'd0);
        rd_reg(3'd5, v); check("R1 rd offset", {32'd0, v}, 64'd0);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        msi_valid = 1'b1; msi_vector = 16'h1234;
        repeat (5) @(negedge clk);
        check("R3 ready while disabled", {63'd0, msi_ready}, 64'd0);
        check("R3 no beat", {63'd0, mem_valid}, 64'd0);
        msi_valid = 1'b0;
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr_reg(3'd3, 32'h0000_0001);
        wr_reg(3'd4, 32'h8000_0005);
        exp_base = 64'h0000_0001_8000_0000;
        rd_reg(3'd4, v); check("R2 base lo aligned", {32'd0, v}, 64'h8000_0000);
        rd_reg(3'd3, v); check("R2 base hi", {32'd0, v}, 64'h1);
        wr_reg(3'd0, 32'hFFFF_FFFF);
        rd_reg(3'd0, v); check("R2 ctrl mask", {32'd0, v}, 64'h31B);
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd6, 32'h0000_1230);
        rd_reg(3'd6, v); check("R2 wr offset read-only", {32'd0, v}, 64'd0);
        wr_reg(3'd5, 32'hFFFF_FFFF);
        rd_reg(3'd5, v); check("R2 rd offset field", {32'd0, v}, 64'h3FFF0);
        wr_reg(3'd5, 32'h0);
    endtask

    task automatic t_record();
        logic [31:0] v;
        wr_reg(3'd0, 32'h0000_0009);
        send(16'hA5C3, 0);
        for (int b = 0; b < 4; b++)
            check("R4 beat addr", got_addr[b], exp_base + 64'(exp_wr) + 64'(4 * b));
        check("R4 word0 vector", {32'd0, got_data[0]}, 64'h0000_A5C3);
        check("R4 word0 low byte", {56'd0, got_data[0][7:0]}, 64'hC3);
        check("R4 word3 zero", {32'd0, got_data[3]}, 64'd0);
        exp_wr = exp_wr + 32'h10;
        rd_reg(3'd6, v); check("R5 wr offset step", {32'd0, v}, {32'd0, exp_wr});
        check("R8 irq pending", {63'd0, irq}, 64'd1);
        wr_reg(3'd5, exp_wr);
        #1 check("R8 irq cleared when equal", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_backpressure();
        logic [31:0] v;
        send(16'h0F0F, 3);
        check("R9 beat1 addr", got_addr[1], exp_base + 64'(exp_wr) + 64'd4);
        exp_wr = exp_wr + 32'h10;
        rd_reg(3'd6, v); check("R5 after stall", {32'd0, v}, {32'd0, exp_wr});
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int bad = 0;
        int cnt = (32'h8000 - exp_wr) / 16;
        for (int i = 0; i < cnt; i++) begin
            send(16'(i), 0);
            if (got_addr[0] !== exp_base + 64'(exp_wr) || got_data[0] !== 32'(16'(i))) bad++;
            exp_wr = (exp_wr + 32'h10) & 32'h7FF0;
        end
        check("R6 records across ring", 64'(bad), 64'd0);
        rd_reg(3'd6, v); check("R6 wrap to zero", {32'd0, v}, 64'd0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        wr_reg(3'd5, 32'h10);
        wr_reg(3'd0, 32'h0000_001B);
        repeat (3) @(negedge clk);
        check("R7 stalled when full", {63'd0, msi_ready}, 64'd0);
        wr_reg(3'd0, 32'h0000_000B);
        #1 check("R7 accept without stop", {63'd0, msi_ready}, 64'd1);
        send(16'h7777, 0);
        rd_reg(3'd6, v); check("R7 overwrite advances", {32'd0, v}, 64'h10);
    endtask

    task automatic t_disable();
        wr_reg(3'd0, 32'h0000_0009);
        wr_reg(3'd5, 32'h40);
        #1 check("R8 irq unequal", {63'd0, irq}, 64'd1);
        wr_reg(3'd0, 32'h0);
        #1 check("R10 irq dropped", {63'd0, irq}, 64'd0);
        check("R10 ready dropped", {63'd0, msi_ready}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        exp_wr = '0;
        exp_base = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_regs();
        t_record();
        t_backpressure();
        t_wrap();
        t_full();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule